// File: doc/BRIEF.md
# Set-Associative Page Translator with Software-Refilled TLB

This block turns a 32-bit virtual address into a physical address for a processor that keeps separate instruction and data translation tables. Each request carries the address, an access kind (read, write, execute), the current process identifier and the live configuration bits. The block answers one cycle later with the physical address, a permission nibble, a fault flag and an exception vector number.

Three paths exist. With translation switched off the address passes through unchanged. With translation on, each of the sixteen 256 MB segments can be set to bypass mode. In that mode a 4-bit base taken from one of two kernel-base words replaces the top address nibble. All other addresses go through a 4-way table with 16 rows per way, one table for instruction fetches and one for data. Software fills the tables through a write port. When a lookup misses, the block records where the refill belongs and why it was needed, so the handler can refill the entry without having to decode the address again.

Top module: `vmap_tlb`

## Requirements
- R1: When `gc_mode` is 0, `rsp_paddr` equals the request address, `rsp_perm` is 4'b0111 and `rsp_fault` is 0. This holds even for a segment marked for bypass. Any nonzero `gc_mode` turns translation on.
- R2: With translation on and `seg_map[va[31:28]]` set, the response carries no fault and `rsp_perm` is 4'b0111. `rsp_paddr` is {base nibble, va[27:0]}. For segment s below 8 the nibble is `kbase_lo[4s+3:4s]`; for s of 8 or more it is `kbase_hi[4(s-8)+3:4(s-8)]`.
- R3: Pages are 8 KB and the VPN is va[31:13]. The row is VPN[3:0], and an entry matches when its hi[31:13] equals the VPN. On a hit `rsp_paddr` is {lo[31:13], va[12:0]} and `rsp_perm` is {lo[2] kernel, lo[0] exec, lo[1] write, 1}.
- R4: When several ways hold the VPN at the row, the lowest-numbered way is used.
- R5: Kind 2 (execute) looks up the instruction table (`tw_bank`=0) and has vector base 4. Kinds 0 (read), 1 (write) and 3 (treated as read) use the data table (`tw_bank`=1) and have base 8.
- R6: A refill fault (vector base+0) occurs when no way matches, or when the chosen entry has lo[4] (global) clear and hi[7:0] differs from `cur_pid`.
- R7: A write to an entry with lo[1] clear, while `chk_write` is 1, faults with vector base+3. This check ranks below refill and above invalid. With `chk_write` at 0 the write hits.
- R8: An entry with lo[3] (valid) clear, while `chk_valid` is 1, faults with vector base+1. With `chk_valid` at 0 the access hits.
- R9: On a refill fault `tsel_q` becomes {way, row}, with the row in bits 3:0 and the way in bits 5:4. The way is the VPN-matching way, or 0 when none matched. `cause_q` becomes {VPN in 31:13, 3'b0, kind in 9:8, cur_pid in 7:0}.
- R10: `tsel_q` and `cause_q` keep their value on every cycle without a refill fault. This includes hits, other faults and bypassed lookups.
- R11: `rsp_valid` follows `req_valid` with one cycle of delay. A table write is seen by a lookup one cycle later, not by a lookup in the same cycle.
- R12: Reset clears `rsp_valid`, `tsel_q`, `cause_q` and every table entry. A cleared entry matches VPN 0 with PID 0, and is non-global and invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| cur_pid | input | 8 | Current process identifier |
| gc_mode | input | 2 | Translation enable field, off when 0 |
| seg_map | input | 16 | Per-segment bypass enables |
| kbase_lo | input | 32 | Base nibbles, segments 0 to 7 |
| kbase_hi | input | 32 | Base nibbles, segments 8 to 15 |
| chk_write | input | 1 | Enable write-protect check |
| chk_valid | input | 1 | Enable valid check |
| tw_en | input | 1 | Table write strobe |
| tw_bank | input | 1 | 0 instruction, 1 data table |
| tw_set | input | 2 | Way to write |
| tw_idx | input | 4 | Row to write |
| tw_hi | input | 32 | VPN in 31:13, PID in 7:0 |
| tw_lo | input | 32 | PFN in 31:13, flags g,v,k,w,x in 4:0 |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 4 | {kernel, exec, write, read} |
| rsp_fault | output | 1 | Lookup faulted |
| rsp_vec | output | 4 | Exception vector, 0 without fault |
| tsel_q | output | 6 | Refill location {way, row} |
| cause_q | output | 32 | Refill cause word |

## Verification
A table of lookups runs against a fixed set of entries. The rows cover PID match, PID mismatch and global entries, so a wrong PID rule shows up as a false hit or a false refill. Entries with the write or valid flag clear are looked up with each check enabled and disabled. One entry has both flags clear, and a write to it shows the fault ranking. The same address is sent as an execute and as a read, which exposes any swap of the two tables or of the vector bases. A VPN duplicated in two ways tests the lowest-way rule. Directed lookups then check the refill record on an empty table and on a PID mismatch in a nonzero way, the decode of both kernel-base words, and that a write is not seen by a lookup in the same cycle.

// File: rtl/vmap_pkg.sv
package vmap_pkg;
  localparam int VA_W      = 32;
  localparam int PAGE_BITS = 13;
  localparam int VPN_W     = VA_W - PAGE_BITS;
  localparam int PID_W     = 8;
  localparam int FLG_W     = 5;

  // flag positions in the low word
  localparam int F_X = 0;
  localparam int F_W = 1;
  localparam int F_K = 2;
  localparam int F_V = 3;
  localparam int F_G = 4;

  localparam logic [1:0] KIND_RD = 2'd0;
  localparam logic [1:0] KIND_WR = 2'd1;
  localparam logic [1:0] KIND_EX = 2'd2;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic [VPN_W-1:0] pfn;
    logic [FLG_W-1:0] flg;
  } tlb_ent_t;

  function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:PAGE_BITS];
  endfunction

  function automatic tlb_ent_t pack_entry(input logic [31:0] hi, input logic [31:0] lo);
    tlb_ent_t e;
    e.vpn = hi[31:PAGE_BITS];
    e.pid = hi[PID_W-1:0];
    e.pfn = lo[31:PAGE_BITS];
    e.flg = lo[FLG_W-1:0];
    return e;
  endfunction

  function automatic logic [3:0] seg_base(input logic [3:0] seg,
                                          input logic [31:0] lo_word,
                                          input logic [31:0] hi_word);
    logic [31:0] w;
    w = seg[3] ? hi_word : lo_word;
    return w[{seg[2:0], 2'b00} +: 4];
  endfunction

  function automatic logic [3:0] vec_base(input logic [1:0] kind);
    return (kind == KIND_EX) ? 4'd4 : 4'd8;
  endfunction

  function automatic logic [31:0] cause_word(input logic [VPN_W-1:0] vpn,
                                             input logic [1:0] kind,
                                             input logic [PID_W-1:0] pid);
    return {vpn, 3'b000, kind, pid};
  endfunction
endpackage

// File: rtl/vmap_bank.sv
module vmap_bank
  import vmap_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int ROWS = 16,
  localparam int SET_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_ent_t         wr_ent,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [VPN_W-1:0] rd_vpn,
  output logic             hit_any,
  output logic [SET_W-1:0] hit_set,
  output logic [PID_W-1:0] hit_pid,
  output logic [VPN_W-1:0] hit_pfn,
  output logic [FLG_W-1:0] hit_flg
);
  tlb_ent_t   mem [WAYS][ROWS];
  logic [WAYS-1:0] way_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++)
        for (int r = 0; r < ROWS; r++)
          mem[w][r] <= '0;
    end else if (wr_en) begin
      mem[wr_set][wr_idx] <= wr_ent;
    end
  end

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_way
      assign way_eq[w] = (mem[w][rd_idx].vpn == rd_vpn);
    end
  endgenerate

  // lowest-numbered matching way wins
  always_comb begin
    hit_set = '0;
    for (int k = WAYS - 1; k >= 0; k--)
      if (way_eq[k]) hit_set = SET_W'(k);
  end

  assign hit_any = |way_eq;
  assign hit_pid = mem[hit_set][rd_idx].pid;
  assign hit_pfn = mem[hit_set][rd_idx].pfn;
  assign hit_flg = mem[hit_set][rd_idx].flg;
endmodule

// File: rtl/vmap_judge.sv
module vmap_judge
  import vmap_pkg::*;
(
  input  logic [1:0]       kind,
  input  logic             found,
  input  logic [PID_W-1:0] ent_pid,
  input  logic             ent_g,
  input  logic             ent_v,
  input  logic             ent_w,
  input  logic [PID_W-1:0] cur_pid,
  input  logic             chk_write,
  input  logic             chk_valid,
  output logic             refill,
  output logic             wprot,
  output logic             inval,
  output logic [3:0]       vec
);
  logic [3:0] base;

  always_comb begin
    base   = vec_base(kind);
    refill = !found || (!ent_g && (ent_pid != cur_pid));
    wprot  = !refill && (kind == KIND_WR) && chk_write && !ent_w;
    inval  = !refill && !wprot && chk_valid && !ent_v;
    if (refill)     vec = base;
    else if (wprot) vec = base + 4'd3;
    else if (inval) vec = base + 4'd1;
    else            vec = 4'd0;
  end
endmodule

// File: rtl/vmap_tlb.sv
module vmap_tlb
  import vmap_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int ROWS = 16,
  localparam int SET_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(ROWS),
  localparam int SEL_W = SET_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic [7:0]       cur_pid,
  input  logic [1:0]       gc_mode,
  input  logic [15:0]      seg_map,
  input  logic [31:0]      kbase_lo,
  input  logic [31:0]      kbase_hi,
  input  logic             chk_write,
  input  logic             chk_valid,
  input  logic             tw_en,
  input  logic             tw_bank,
  input  logic [SET_W-1:0] tw_set,
  input  logic [IDX_W-1:0] tw_idx,
  input  logic [31:0]      tw_hi,
  input  logic [31:0]      tw_lo,
  output logic             rsp_valid,
  output logic [31:0]      rsp_paddr,
  output logic [3:0]       rsp_perm,
  output logic             rsp_fault,
  output logic [3:0]       rsp_vec,
  output logic [SEL_W-1:0] tsel_q,
  output logic [31:0]      cause_q
);
  localparam int NBANK  = 2;
  localparam int BANK_I = 0;
  localparam int BANK_D = 1;

  // named events for the checker
  logic xlate_on, seg_hit, use_tlb;
  logic lk_refill, lk_wprot, lk_inval;

  logic [VPN_W-1:0] va_vpn;
  logic [IDX_W-1:0] va_idx;
  logic             bsel;
  tlb_ent_t         wr_ent;
  logic             unused_tw_bits;

  logic [NBANK-1:0] b_any;
  logic [SET_W-1:0] b_set [NBANK];
  logic [PID_W-1:0] b_pid [NBANK];
  logic [VPN_W-1:0] b_pfn [NBANK];
  logic [FLG_W-1:0] b_flg [NBANK];

  logic             j_refill, j_wprot, j_inval;
  logic [3:0]       j_vec;
  logic [FLG_W-1:0] s_flg;

  logic [31:0] pa_n;
  logic [3:0]  perm_n;

  assign xlate_on = |gc_mode;
  assign seg_hit  = xlate_on && seg_map[req_vaddr[31:28]];
  assign use_tlb  = xlate_on && !seg_hit;
  assign va_vpn   = page_of(req_vaddr);
  assign va_idx   = va_vpn[IDX_W-1:0];
  assign bsel     = (req_kind == KIND_EX) ? 1'(BANK_I) : 1'(BANK_D);
  assign wr_ent   = pack_entry(tw_hi, tw_lo);
  assign unused_tw_bits = ^{tw_hi[PAGE_BITS-1:PID_W], tw_lo[PAGE_BITS-1:FLG_W]};

  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bank
      vmap_bank #(.WAYS(WAYS), .ROWS(ROWS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tw_en && (tw_bank == 1'(b))),
        .wr_set  (tw_set),
        .wr_idx  (tw_idx),
        .wr_ent  (wr_ent),
        .rd_idx  (va_idx),
        .rd_vpn  (va_vpn),
        .hit_any (b_any[b]),
        .hit_set (b_set[b]),
        .hit_pid (b_pid[b]),
        .hit_pfn (b_pfn[b]),
        .hit_flg (b_flg[b])
      );
    end
  endgenerate

  assign s_flg = b_flg[bsel];

  vmap_judge u_judge (
    .kind      (req_kind),
    .found     (b_any[bsel]),
    .ent_pid   (b_pid[bsel]),
    .ent_g     (s_flg[F_G]),
    .ent_v     (s_flg[F_V]),
    .ent_w     (s_flg[F_W]),
    .cur_pid   (cur_pid),
    .chk_write (chk_write),
    .chk_valid (chk_valid),
    .refill    (j_refill),
    .wprot     (j_wprot),
    .inval     (j_inval),
    .vec       (j_vec)
  );

  assign lk_refill = use_tlb && j_refill;
  assign lk_wprot  = use_tlb && j_wprot;
  assign lk_inval  = use_tlb && j_inval;

  always_comb begin
    if (!xlate_on) begin
      pa_n   = req_vaddr;
      perm_n = 4'b0111;
    end else if (seg_hit) begin
      pa_n   = {seg_base(req_vaddr[31:28], kbase_lo, kbase_hi), req_vaddr[27:0]};
      perm_n = 4'b0111;
    end else begin
      pa_n   = {b_pfn[bsel], req_vaddr[PAGE_BITS-1:0]};
      perm_n = {s_flg[F_K], s_flg[F_X], s_flg[F_W], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
      rsp_fault <= 1'b0;
      rsp_vec   <= '0;
      tsel_q    <= '0;
      cause_q   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr <= pa_n;
        rsp_perm  <= perm_n;
        rsp_fault <= lk_refill || lk_wprot || lk_inval;
        rsp_vec   <= use_tlb ? j_vec : 4'd0;
        if (lk_refill) begin
          tsel_q  <= {(b_any[bsel] ? b_set[bsel] : SET_W'(0)), va_idx};
          cause_q <= cause_word(va_vpn, req_kind, cur_pid);
        end
      end
    end
  end
endmodule

// File: rtl/vmap_chk.sv
module vmap_chk #(
  parameter int SEL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [31:0]      req_vaddr,
  input logic [1:0]       req_kind,
  input logic [7:0]       cur_pid,
  input logic [1:0]       gc_mode,
  input logic [15:0]      seg_map,
  input logic             rsp_valid,
  input logic [31:0]      rsp_paddr,
  input logic [3:0]       rsp_perm,
  input logic             rsp_fault,
  input logic [3:0]       rsp_vec,
  input logic [SEL_W-1:0] tsel_q,
  input logic [31:0]      cause_q,
  input logic             lk_refill,
  input logic             lk_wprot,
  input logic             lk_inval
);
  a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && gc_mode == 2'd0 |=>
      rsp_paddr == $past(req_vaddr) && rsp_perm == 4'b0111 && !rsp_fault);

  a_r2_seg_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && gc_mode != 2'd0 && seg_map[req_vaddr[31:28]] |=>
      !rsp_fault && rsp_perm == 4'b0111 && rsp_paddr[27:0] == $past(req_vaddr[27:0]));

  a_r5_exec_base: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'd2 && (lk_refill || lk_wprot || lk_inval) |=>
      rsp_fault && rsp_vec[3:2] == 2'b01);

  a_r5_data_base: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind != 2'd2 && (lk_refill || lk_wprot || lk_inval) |=>
      rsp_fault && rsp_vec[3:2] == 2'b10);

  a_r7_one_reason: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_refill, lk_wprot, lk_inval}));

  a_r9_cause_fill: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && lk_refill |=>
      cause_q[31:13] == $past(req_vaddr[31:13]) && cause_q[9:8] == $past(req_kind) &&
      cause_q[7:0] == $past(cur_pid) && rsp_vec[1:0] == 2'd0 &&
      tsel_q[3:0] == $past(req_vaddr[16:13]));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && lk_refill) |=> $stable(cause_q) && $stable(tsel_q));

  a_r11_rsp_on: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r11_rsp_off: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r6_no_vec_without_fault: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_vec == 4'd0);
endmodule

bind vmap_tlb vmap_chk #(.SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_vaddr (req_vaddr),
  .req_kind  (req_kind),
  .cur_pid   (cur_pid),
  .gc_mode   (gc_mode),
  .seg_map   (seg_map),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr),
  .rsp_perm  (rsp_perm),
  .rsp_fault (rsp_fault),
  .rsp_vec   (rsp_vec),
  .tsel_q    (tsel_q),
  .cause_q   (cause_q),
  .lk_refill (lk_refill),
  .lk_wprot  (lk_wprot),
  .lk_inval  (lk_inval)
);

// File: tb/vmap_tlb_tb.sv
module vmap_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic [7:0]  cur_pid = '0;
  logic [1:0]  gc_mode = 2'd1;
  logic [15:0] seg_map = '0;
  logic [31:0] kbase_lo = 32'h0000_5000;
  logic [31:0] kbase_hi = 32'h000A_0000;
  logic        chk_write = 1'b1;
  logic        chk_valid = 1'b1;
  logic        tw_en = 1'b0;
  logic        tw_bank = 1'b0;
  logic [1:0]  tw_set = '0;
  logic [3:0]  tw_idx = '0;
  logic [31:0] tw_hi = '0;
  logic [31:0] tw_lo = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [3:0]  rsp_perm;
  logic        rsp_fault;
  logic [3:0]  rsp_vec;
  logic [5:0]  tsel_q;
  logic [31:0] cause_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vmap_tlb u_dut (.*);

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  kind;
    logic [7:0]  pid;
    logic [1:0]  gc;
    logic        wchk;
    logic        vchk;
    logic        fault;
    logic [3:0]  vec;
    logic [31:0] pa;
    logic [3:0]  perm;
  } row_t;

  localparam int NROW = 19;
  localparam row_t TBL [NROW] = '{
    '{32'h0000_2123, 2'd0, 8'h12, 2'd1, 1'b1, 1'b1, 1'b0, 4'd0,  32'h0020_0123, 4'b0011}, // R3 PID match
    '{32'h0000_2124, 2'd1, 8'h12, 2'd1, 1'b1, 1'b1, 1'b0, 4'd0,  32'h0020_0124, 4'b0011}, // R3 writable
    '{32'h0000_2000, 2'd0, 8'h13, 2'd1, 1'b1, 1'b1, 1'b1, 4'd8,  32'h0,         4'b0},    // R6 PID mismatch
    '{32'h0002_2010, 2'd0, 8'h55, 2'd1, 1'b1, 1'b1, 1'b0, 4'd0,  32'h0040_0010, 4'b0001}, // R6 global
    '{32'h0002_2010, 2'd1, 8'h55, 2'd1, 1'b1, 1'b1, 1'b1, 4'd11, 32'h0,         4'b0},    // R7
    '{32'h0002_2010, 2'd1, 8'h55, 2'd1, 1'b0, 1'b1, 1'b0, 4'd0,  32'h0040_0010, 4'b0001}, // R7 check off
    '{32'h0000_4000, 2'd0, 8'h12, 2'd1, 1'b1, 1'b1, 1'b1, 4'd9,  32'h0,         4'b0},    // R8
    '{32'h0000_4000, 2'd0, 8'h12, 2'd1, 1'b1, 1'b0, 1'b0, 4'd0,  32'h0060_0000, 4'b0011}, // R8 check off
    '{32'h0000_2040, 2'd2, 8'h12, 2'd1, 1'b1, 1'b1, 1'b0, 4'd0,  32'h000A_A040, 4'b0101}, // R5 instr table
    '{32'h0002_2000, 2'd2, 8'h12, 2'd1, 1'b1, 1'b1, 1'b1, 4'd4,  32'h0,         4'b0},    // R5 instr base
    '{32'h0000_6ABC, 2'd0, 8'h12, 2'd1, 1'b1, 1'b1, 1'b0, 4'd0,  32'h0080_2ABC, 4'b0011}, // R4 lowest way
    '{32'h0000_4000, 2'd2, 8'h12, 2'd1, 1'b1, 1'b1, 1'b1, 4'd4,  32'h0,         4'b0},    // R5 not in instr
    '{32'hDEAD_BEEF, 2'd1, 8'h12, 2'd0, 1'b1, 1'b1, 1'b0, 4'd0,  32'hDEAD_BEEF, 4'b0111}, // R1
    '{32'h0000_2010, 2'd3, 8'h12, 2'd1, 1'b1, 1'b1, 1'b0, 4'd0,  32'h0020_0010, 4'b0011}, // R5 kind 3
    '{32'h0000_4000, 2'd1, 8'h12, 2'd1, 1'b1, 1'b1, 1'b1, 4'd9,  32'h0,         4'b0},    // R8 writable
    '{32'h0000_A000, 2'd1, 8'h12, 2'd1, 1'b1, 1'b1, 1'b1, 4'd11, 32'h0,         4'b0},    // R7 over R8
    '{32'h0000_A000, 2'd0, 8'h12, 2'd1, 1'b1, 1'b1, 1'b1, 4'd9,  32'h0,         4'b0},    // R8
    '{32'h0000_8000, 2'd1, 8'h12, 2'd1, 1'b1, 1'b1, 1'b1, 4'd8,  32'h0,         4'b0},    // R6 no entry
    '{32'h0000_2123, 2'd0, 8'h12, 2'd2, 1'b1, 1'b1, 1'b0, 4'd0,  32'h0020_0123, 4'b0011}  // R1 other mode
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic twrite(input logic bank, input logic [1:0] set, input logic [3:0] idx,
                        input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    tw_en = 1'b1; tw_bank = bank; tw_set = set; tw_idx = idx; tw_hi = hi; tw_lo = lo;
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] kind, input logic [7:0] pid);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; cur_pid = pid;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 rsp_valid", 32'(rsp_valid), 0);
    check("R12 tsel", 32'(tsel_q), 0);
    check("R12 cause", cause_q, 0);
    rst_n = 1'b1;

    // R12 empty table: refill, R9 record
    lookup(32'h0000_A000, 2'd0, 8'h05);
    check("R12 empty fault", 32'(rsp_fault), 1);
    check("R12 empty vec", 32'(rsp_vec), 8);
    check("R9 cause empty", cause_q, 32'h0000_A005);
    check("R9 tsel empty", 32'(tsel_q), 32'h05);

    // table fill
    twrite(1'b1, 2'd0, 4'd1, 32'h0000_2012, 32'h0020_000A);
    twrite(1'b1, 2'd1, 4'd1, 32'h0002_2077, 32'h0040_0018);
    twrite(1'b1, 2'd2, 4'd2, 32'h0000_4012, 32'h0060_0002);
    twrite(1'b1, 2'd1, 4'd3, 32'h0000_6000, 32'h0080_201A);
    twrite(1'b1, 2'd3, 4'd3, 32'h0000_6000, 32'h00FF_E01A);
    twrite(1'b1, 2'd3, 4'd5, 32'h0000_A000, 32'h0024_6010);
    twrite(1'b0, 2'd0, 4'd1, 32'h0000_2012, 32'h000A_A009);

    for (int i = 0; i < NROW; i++) begin
      gc_mode = TBL[i].gc; chk_write = TBL[i].wchk; chk_valid = TBL[i].vchk;
      lookup(TBL[i].va, TBL[i].kind, TBL[i].pid);
      if (TBL[i].fault)
        tag = (TBL[i].vec[1:0] == 2'd0) ? "R6 row" : (TBL[i].vec[1:0] == 2'd3) ? "R7 row" : "R8 row";
      else
        tag = (TBL[i].gc == 2'd0) ? "R1 row" : "R3 row";
      check($sformatf("%s %0d valid", tag, i), 32'(rsp_valid), 1);
      check($sformatf("%s %0d fault", tag, i), 32'(rsp_fault), 32'(TBL[i].fault));
      check($sformatf("%s %0d vec", tag, i), 32'(rsp_vec), 32'(TBL[i].vec));
      if (!TBL[i].fault) begin
        check($sformatf("%s %0d paddr", tag, i), rsp_paddr, TBL[i].pa);
        check($sformatf("%s %0d perm", tag, i), 32'(rsp_perm), 32'(TBL[i].perm));
      end
    end
    gc_mode = 2'd1; chk_write = 1'b1; chk_valid = 1'b1;

    // R9 PID mismatch in way 2
    lookup(32'h0000_4000, 2'd0, 8'h99);
    check("R9 vec", 32'(rsp_vec), 8);
    check("R9 tsel way2", 32'(tsel_q), 32'h22);
    check("R9 cause pid", cause_q, 32'h0000_4099);
    // R10 hit leaves record
    lookup(32'h0000_2123, 2'd0, 8'h12);
    check("R10 hit fault", 32'(rsp_fault), 0);
    check("R10 tsel", 32'(tsel_q), 32'h22);
    check("R10 cause", cause_q, 32'h0000_4099);
    // R9 execute kind in cause
    lookup(32'h0002_2000, 2'd2, 8'h12);
    check("R9 exec cause", cause_q, 32'h0002_2212);
    check("R9 exec tsel", 32'(tsel_q), 32'h01);
    // R10 other fault leaves record
    lookup(32'h0000_4000, 2'd0, 8'h12);
    check("R10 inval vec", 32'(rsp_vec), 9);
    check("R10 cause after inval", cause_q, 32'h0002_2212);

    // R2 segment bypass, both base words
    seg_map = 16'h1008;
    lookup(32'hC123_4567, 2'd0, 8'h00);
    check("R2 seg12 paddr", rsp_paddr, 32'hA123_4567);
    check("R2 seg12 fault", 32'(rsp_fault), 0);
    check("R2 seg12 perm", 32'(rsp_perm), 32'h7);
    lookup(32'h3000_0010, 2'd1, 8'h00);
    check("R2 seg3 paddr", rsp_paddr, 32'h5000_0010);
    check("R10 cause after bypass", cause_q, 32'h0002_2212);
    gc_mode = 2'd0;
    lookup(32'hC123_4567, 2'd0, 8'h00);
    check("R1 over seg", rsp_paddr, 32'hC123_4567);
    gc_mode = 2'd1; seg_map = '0;

    // R11 write in same cycle as lookup is not seen
    @(negedge clk);
    tw_en = 1'b1; tw_bank = 1'b1; tw_set = 2'd0; tw_idx = 4'd6;
    tw_hi = 32'h0000_C012; tw_lo = 32'h0015_601A;
    req_valid = 1'b1; req_vaddr = 32'h0000_C000; req_kind = 2'd0; cur_pid = 8'h12;
    @(negedge clk);
    tw_en = 1'b0;
    check("R11 same-cycle fault", 32'(rsp_fault), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 next fault", 32'(rsp_fault), 0);
    check("R11 next paddr", rsp_paddr, 32'h0015_6000);
    @(negedge clk);
    check("R11 idle valid", 32'(rsp_valid), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule